// File: doc/BRIEF.md
# Bit-Serial SIMD Pixel Processor Array

This block is a rectangular grid of one-bit processing cells, one cell per pixel of an image tile. Every cell executes the same instruction in the same cycle. A cell owns a small addressable bit memory, a carry bit and an activity bit. Its datapath is a single three-input lookup: the instruction supplies an 8-bit truth table, and the three input bits pick one entry of it. Two of the input bits are read from the cell's memory. The third is either the cell's carry or a bit read from one of its four direct neighbours. A second 8-bit table, indexed the same way, gives the next carry. Because the carry is kept from one instruction to the next, word-wide addition and comparison run as a sequence of instructions, least significant bit first.

Grey-scale frames enter and leave one bit-plane at a time. In a shift instruction every row acts as a shift chain running from west to east. The external column input feeds the west edge of each row, and the east-edge cells drive the column output. A controller can also observe a single global flag. This flag is the OR, over all cells, of the memory bit at the first source address of the previous instruction. It can be used to end loops or to detect that an image region is empty.

Top module: `pxa_array`

## Requirements
- R1: After synchronous reset every memory bit and every carry is 0, every cell is active, and `any_flag` is 0.
- R2: An ALU instruction (`op_kind`=1) writes `res_fn[idx]` into memory bit `dst_addr` of every active cell, where idx = 4*a + 2*b + c. Here a is memory bit `src_a`, b is memory bit `src_b`, and c is the third input.
- R3: `nbr_sel` chooses the third input c: 0 is the cell's own carry, 1 is the north neighbour (row−1), 2 is the south neighbour (row+1), 3 is the east neighbour (column+1) and 4 is the west neighbour (column−1). A neighbour value is that neighbour's memory bit `src_a`. A neighbour outside the grid, and the codes 5 to 7, give 0.
- R4: In an ALU instruction the carry of every active cell takes `carry_fn[idx]`, using the same idx. No other instruction changes the carry. Chained ALU steps with sum table 8'h96 and carry table 8'hE8 produce a bit-serial sum.
- R5: An inactive cell writes neither memory nor carry in an ALU instruction. A mask instruction (`op_kind`=3) writes `res_fn[idx]` into the activity bit of every cell, whether active or not. No other instruction changes the activity bits.
- R6: In a shift instruction (`op_kind`=2), every cell writes memory bit `dst_addr` from its west neighbour's bit `src_a`. In column 0 the value comes from `col_in[row]`. The activity bits have no effect on a shift.
- R7: `col_out[row]` shows, without a clock edge, memory bit `src_a` of the east-most cell of that row.
- R8: `any_flag` is a register. After each clock edge it equals the OR, over all cells, of memory bit `src_a` as it stood before that edge.
- R9: A no-operation instruction (`op_kind`=0) leaves memory, carry and activity bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_kind | input | 2 | 0 no-op, 1 ALU, 2 shift, 3 mask write |
| src_a | input | ADDR_W | First source bit address; also the neighbour, shift, column-output and flag read address |
| src_b | input | ADDR_W | Second source bit address |
| dst_addr | input | ADDR_W | Destination bit address |
| res_fn | input | 8 | Truth table for the result bit |
| carry_fn | input | 8 | Truth table for the next carry |
| nbr_sel | input | 3 | Third-input select |
| col_in | input | ROWS | West-edge shift input, one bit per row |
| col_out | output | ROWS | East-edge read-out, one bit per row |
| any_flag | output | 1 | Registered global OR |

## Verification
Memory, carry and activity bits change at the clock edge on which their instruction is presented. The bench applies each instruction at the falling edge and samples one step after the following rising edge. `col_out` has no register, so the bench samples it inside the same cycle, after setting `src_a` and before the shift edge. Bit-planes are read out over ROWS-wide columns in COLS cycles, east column first. `any_flag` is due one edge after its address is presented. The bench checks that it is still unchanged before that edge and correct just after it.

// File: rtl/pxa_pkg.sv
package pxa_pkg;

    localparam int ADDR_W = 7;
    localparam int FN_W   = 8;

    typedef enum logic [1:0] {
        OPK_NOP   = 2'd0,
        OPK_ALU   = 2'd1,
        OPK_SHIFT = 2'd2,
        OPK_MASK  = 2'd3
    } opk_e;

    localparam logic [2:0] NB_SELF  = 3'd0;
    localparam logic [2:0] NB_NORTH = 3'd1;
    localparam logic [2:0] NB_SOUTH = 3'd2;
    localparam logic [2:0] NB_EAST  = 3'd3;
    localparam logic [2:0] NB_WEST  = 3'd4;

    typedef struct packed {
        opk_e              kind;
        logic [ADDR_W-1:0] src_a;
        logic [ADDR_W-1:0] src_b;
        logic [ADDR_W-1:0] dst;
        logic [FN_W-1:0]   res_fn;
        logic [FN_W-1:0]   cy_fn;
        logic [2:0]        nbr;
    } instr_t;

    typedef struct packed {
        logic north;
        logic south;
        logic east;
        logic west;
    } links_t;

    // Index of a three-input truth table: a is the most significant bit.
    function automatic logic tt_lookup(input logic [FN_W-1:0] fn,
                                       input logic a, input logic b,
                                       input logic c);
        return fn[{a, b, c}];
    endfunction

endpackage

// File: rtl/pxa_cell.sv
module pxa_cell
    import pxa_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  instr_t ins,
    input  links_t nb,
    input  logic   shift_src,
    output logic   rd_a,
    output logic   carry_o,
    output logic   mask_o
);
    localparam int MEM_BITS = 1 << ADDR_W;

    logic [MEM_BITS-1:0] mem_q;
    logic                carry_q;
    logic                mask_q;
    logic                bit_b;
    logic                bit_c;
    logic                res_bit;
    logic                cy_bit;

    assign rd_a  = mem_q[ins.src_a];
    assign bit_b = mem_q[ins.src_b];

    always_comb begin
        case (ins.nbr)
            NB_SELF:  bit_c = carry_q;
            NB_NORTH: bit_c = nb.north;
            NB_SOUTH: bit_c = nb.south;
            NB_EAST:  bit_c = nb.east;
            NB_WEST:  bit_c = nb.west;
            default:  bit_c = 1'b0;
        endcase
    end

    assign res_bit = tt_lookup(ins.res_fn, rd_a, bit_b, bit_c);
    assign cy_bit  = tt_lookup(ins.cy_fn,  rd_a, bit_b, bit_c);

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q   <= '0;
            carry_q <= 1'b0;
            mask_q  <= 1'b1;
        end else begin
            case (ins.kind)
                OPK_ALU: begin
                    if (mask_q) begin
                        mem_q[ins.dst] <= res_bit;
                        carry_q        <= cy_bit;
                    end
                end
                OPK_SHIFT: mem_q[ins.dst] <= shift_src;
                OPK_MASK:  mask_q         <= res_bit;
                default: ;
            endcase
        end
    end

    assign carry_o = carry_q;
    assign mask_o  = mask_q;

endmodule

// File: rtl/pxa_any.sv
module pxa_any #(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] bits,
    output logic         flag
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= |bits;
    end

    assign flag = flag_q;

endmodule

// File: rtl/pxa_array.sv
module pxa_array
    import pxa_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        op_kind,
    input  logic [ADDR_W-1:0] src_a,
    input  logic [ADDR_W-1:0] src_b,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [FN_W-1:0]   res_fn,
    input  logic [FN_W-1:0]   carry_fn,
    input  logic [2:0]        nbr_sel,
    input  logic [ROWS-1:0]   col_in,
    output logic [ROWS-1:0]   col_out,
    output logic              any_flag
);
    localparam int CELLS = ROWS * COLS;

    instr_t            ins;
    logic [CELLS-1:0]  rd_a_vec;
    logic [CELLS-1:0]  carry_vec;
    logic [CELLS-1:0]  mask_vec;
    logic [CELLS-1:0]  shift_vec;
    links_t            links [CELLS];

    assign ins.kind   = opk_e'(op_kind);
    assign ins.src_a  = src_a;
    assign ins.src_b  = src_b;
    assign ins.dst    = dst_addr;
    assign ins.res_fn = res_fn;
    assign ins.cy_fn  = carry_fn;
    assign ins.nbr    = nbr_sel;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int IDX = r * COLS + c;

            if (r > 0) begin : g_n
                assign links[IDX].north = rd_a_vec[IDX - COLS];
            end else begin : g_n_edge
                assign links[IDX].north = 1'b0;
            end

            if (r < ROWS - 1) begin : g_s
                assign links[IDX].south = rd_a_vec[IDX + COLS];
            end else begin : g_s_edge
                assign links[IDX].south = 1'b0;
            end

            if (c < COLS - 1) begin : g_e
                assign links[IDX].east = rd_a_vec[IDX + 1];
            end else begin : g_e_edge
                assign links[IDX].east = 1'b0;
            end

            if (c > 0) begin : g_w
                assign links[IDX].west = rd_a_vec[IDX - 1];
                assign shift_vec[IDX]  = rd_a_vec[IDX - 1];
            end else begin : g_w_edge
                assign links[IDX].west = 1'b0;
                assign shift_vec[IDX]  = col_in[r];
            end

            pxa_cell cell_i (
                .clk       (clk),
                .rst       (rst),
                .ins       (ins),
                .nb        (links[IDX]),
                .shift_src (shift_vec[IDX]),
                .rd_a      (rd_a_vec[IDX]),
                .carry_o   (carry_vec[IDX]),
                .mask_o    (mask_vec[IDX])
            );
        end

        assign col_out[r] = rd_a_vec[r * COLS + COLS - 1];
    end

    pxa_any #(.N(CELLS)) any_i (
        .clk  (clk),
        .rst  (rst),
        .bits (rd_a_vec),
        .flag (any_flag)
    );

endmodule

// File: rtl/pxa_array_chk.sv
module pxa_array_chk #(
    parameter int CELLS = 64
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       op_kind,
    input logic             any_flag,
    input logic [CELLS-1:0] rd_a_vec,
    input logic [CELLS-1:0] carry_vec,
    input logic [CELLS-1:0] mask_vec
);
    // R1: state seen in the first cycle after reset is released
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ((&mask_vec) && (carry_vec == '0) && !any_flag));

    // R4: only ALU instructions may move the carry bits
    a_r4_carry_hold: assert property (@(posedge clk) disable iff (rst)
        (op_kind != 2'd1) |=> $stable(carry_vec));

    // R5: only mask instructions may move the activity bits
    a_r5_mask_hold: assert property (@(posedge clk) disable iff (rst)
        (op_kind != 2'd3) |=> $stable(mask_vec));

    // R8: the flag follows the cells' read bits one edge later
    a_r8_flag_delay: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (any_flag == $past(|rd_a_vec)));

endmodule

bind pxa_array pxa_array_chk #(.CELLS(ROWS * COLS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .op_kind   (op_kind),
    .any_flag  (any_flag),
    .rd_a_vec  (rd_a_vec),
    .carry_vec (carry_vec),
    .mask_vec  (mask_vec)
);

// File: tb/pxa_array_tb_top.sv
module pxa_array_tb_top;
    localparam int ROWS  = 8;
    localparam int COLS  = 8;
    localparam int CELLS = ROWS * COLS;
    localparam int AW    = 7;

    typedef struct packed {
        logic [7:0]       fn;
        logic [CELLS-1:0] expv;
    } vec_t;

    localparam logic [CELLS-1:0] PL_A = 64'hFF00FF00FF00FF00;
    localparam logic [CELLS-1:0] PL_B = 64'hF0F0F0F0F0F0F0F0;

    // R2: result tables applied to PL_A (a) and PL_B (b), carry input 0
    localparam vec_t VECS [6] = '{
        '{8'hC0, 64'hF000F000F000F000},   // a and b
        '{8'hFC, 64'hFFF0FFF0FFF0FFF0},   // a or b
        '{8'h3C, 64'h0FF00FF00FF00FF0},   // a xor b
        '{8'h0F, 64'h00FF00FF00FF00FF},   // not a
        '{8'hCC, 64'hF0F0F0F0F0F0F0F0},   // b
        '{8'h30, 64'h0F000F000F000F00}    // a and not b
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [1:0]      op_kind = 2'd0;
    logic [AW-1:0]   src_a = '0;
    logic [AW-1:0]   src_b = '0;
    logic [AW-1:0]   dst_addr = '0;
    logic [7:0]      res_fn = '0;
    logic [7:0]      carry_fn = '0;
    logic [2:0]      nbr_sel = '0;
    logic [ROWS-1:0] col_in = '0;
    logic [ROWS-1:0] col_out;
    logic            any_flag;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pxa_array #(.ROWS(ROWS), .COLS(COLS)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .op_kind  (op_kind),
        .src_a    (src_a),
        .src_b    (src_b),
        .dst_addr (dst_addr),
        .res_fn   (res_fn),
        .carry_fn (carry_fn),
        .nbr_sel  (nbr_sel),
        .col_in   (col_in),
        .col_out  (col_out),
        .any_flag (any_flag)
    );

    task automatic check(input string req, input logic [CELLS-1:0] act,
                         input logic [CELLS-1:0] expv);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic issue(input logic [1:0] k, input int a, input int b,
                         input int d, input logic [7:0] f,
                         input logic [7:0] cf, input logic [2:0] nb);
        @(negedge clk);
        op_kind  = k;
        src_a    = AW'(a);
        src_b    = AW'(b);
        dst_addr = AW'(d);
        res_fn   = f;
        carry_fn = cf;
        nbr_sel  = nb;
        @(posedge clk);
        #1 op_kind = 2'd0;
    endtask

    // R6: feed a plane through the row chains, east-most column first
    task automatic load_plane(input int addr, input logic [CELLS-1:0] pl);
        for (int k = 0; k < COLS; k++) begin
            @(negedge clk);
            op_kind  = 2'd2;
            src_a    = AW'(addr);
            dst_addr = AW'(addr);
            for (int r = 0; r < ROWS; r++)
                col_in[r] = pl[r * COLS + COLS - 1 - k];
            @(posedge clk);
            #1 op_kind = 2'd0;
        end
    endtask

    // R7: sample the east column before each shift edge (destroys the plane)
    task automatic read_plane(input int addr, output logic [CELLS-1:0] pl);
        pl = '0;
        for (int k = 0; k < COLS; k++) begin
            @(negedge clk);
            op_kind  = 2'd2;
            src_a    = AW'(addr);
            dst_addr = AW'(addr);
            col_in   = '0;
            #1;
            for (int r = 0; r < ROWS; r++)
                pl[r * COLS + COLS - 1 - k] = col_out[r];
            @(posedge clk);
            #1 op_kind = 2'd0;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [CELLS-1:0] pl;
        logic [CELLS-1:0] xp [4];
        logic [CELLS-1:0] yp [4];
        logic [CELLS-1:0] sp [5];

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: flag, memory, activity and carry after reset
        check("R1 flag", {63'b0, any_flag}, '0);
        read_plane(0, pl);
        check("R1 memory", pl, '0);
        issue(2'd1, 0, 0, 45, 8'hFF, 8'h00, 3'd0);
        read_plane(45, pl);
        check("R1 all active", pl, '1);
        issue(2'd1, 0, 0, 46, 8'hAA, 8'h00, 3'd0);
        read_plane(46, pl);
        check("R1 carry clear", pl, '0);

        // R2: table-driven truth-table walk
        load_plane(1, PL_A);
        load_plane(2, PL_B);
        foreach (VECS[i]) begin
            issue(2'd1, 1, 2, 3, VECS[i].fn, 8'h00, 3'd0);
            read_plane(3, pl);
            check($sformatf("R2 table fn=%h", VECS[i].fn), pl, VECS[i].expv);
        end

        // R3: neighbour selection from a single set bit at row 3, column 3
        load_plane(5, 64'(1) << 27);
        issue(2'd1, 5, 5, 6, 8'hAA, 8'h00, 3'd1);
        read_plane(6, pl);
        check("R3 north", pl, 64'(1) << 35);
        load_plane(5, 64'(1) << 27);
        issue(2'd1, 5, 5, 6, 8'hAA, 8'h00, 3'd2);
        read_plane(6, pl);
        check("R3 south", pl, 64'(1) << 19);
        load_plane(5, 64'(1) << 27);
        issue(2'd1, 5, 5, 6, 8'hAA, 8'h00, 3'd3);
        read_plane(6, pl);
        check("R3 east", pl, 64'(1) << 26);
        load_plane(5, 64'(1) << 27);
        issue(2'd1, 5, 5, 6, 8'hAA, 8'h00, 3'd4);
        read_plane(6, pl);
        check("R3 west", pl, 64'(1) << 28);

        // R3: grid edges and unused select codes give 0
        load_plane(7, '1);
        issue(2'd1, 7, 7, 8, 8'hAA, 8'h00, 3'd1);
        read_plane(8, pl);
        check("R3 north edge", pl, 64'hFFFFFFFFFFFFFF00);
        issue(2'd1, 7, 7, 8, 8'hAA, 8'h00, 3'd3);
        read_plane(8, pl);
        check("R3 east edge", pl, 64'h7F7F7F7F7F7F7F7F);
        issue(2'd1, 7, 7, 8, 8'hAA, 8'h00, 3'd5);
        read_plane(8, pl);
        check("R3 code 5", pl, '0);

        // R4: 4-bit bit-serial add per pixel, x = p mod 16, y = (3p+5) mod 16
        for (int i = 0; i < 4; i++) begin
            xp[i] = '0;
            yp[i] = '0;
        end
        for (int i = 0; i < 5; i++) sp[i] = '0;
        for (int p = 0; p < CELLS; p++) begin
            int x;
            int y;
            int s;
            x = p % 16;
            y = (3 * p + 5) % 16;
            s = x + y;
            for (int i = 0; i < 4; i++) begin
                xp[i][p] = x[i];
                yp[i][p] = y[i];
            end
            for (int i = 0; i < 5; i++) sp[i][p] = s[i];
        end
        for (int i = 0; i < 4; i++) begin
            load_plane(10 + i, xp[i]);
            load_plane(20 + i, yp[i]);
        end
        issue(2'd1, 0, 0, 60, 8'h00, 8'h00, 3'd0);
        for (int i = 0; i < 4; i++)
            issue(2'd1, 10 + i, 20 + i, 30 + i, 8'h96, 8'hE8, 3'd0);
        issue(2'd1, 0, 0, 34, 8'hAA, 8'h00, 3'd0);
        for (int i = 0; i < 5; i++) begin
            read_plane(30 + i, pl);
            check($sformatf("R4 sum bit %0d", i), pl, sp[i]);
        end

        // R5: activity mask gates memory and carry writes
        issue(2'd3, 1, 0, 0, 8'hF0, 8'h00, 3'd0);
        issue(2'd1, 0, 0, 41, 8'hFF, 8'hFF, 3'd0);
        read_plane(41, pl);
        check("R5 masked write", pl, PL_A);
        issue(2'd3, 0, 0, 0, 8'hFF, 8'h00, 3'd0);
        issue(2'd1, 0, 0, 42, 8'hAA, 8'h00, 3'd0);
        read_plane(42, pl);
        check("R5 masked carry", pl, PL_A);

        // R6: shift ignores an all-inactive mask; R5 mask op still writes
        issue(2'd3, 0, 0, 0, 8'h00, 8'h00, 3'd0);
        load_plane(43, PL_B);
        read_plane(43, pl);
        check("R6 shift under mask", pl, PL_B);
        issue(2'd3, 0, 0, 0, 8'hFF, 8'h00, 3'd0);
        issue(2'd1, 0, 0, 47, 8'hFF, 8'h00, 3'd0);
        read_plane(47, pl);
        check("R5 mask op restores", pl, '1);

        // R9: a no-op leaves memory alone
        load_plane(44, PL_B);
        issue(2'd0, 0, 0, 44, 8'h00, 8'h00, 3'd0);
        read_plane(44, pl);
        check("R9 nop", pl, PL_B);

        // R8: flag timing, one edge after the address is presented
        issue(2'd0, 50, 0, 0, 8'h00, 8'h00, 3'd0);
        check("R8 flag empty", {63'b0, any_flag}, '0);
        load_plane(51, 64'(1) << 40);
        issue(2'd0, 50, 0, 0, 8'h00, 8'h00, 3'd0);
        @(negedge clk);
        src_a = AW'(51);
        #1 check("R8 flag not early", {63'b0, any_flag}, '0);
        @(posedge clk);
        #1 check("R8 flag set", {63'b0, any_flag}, 64'd1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule